// File: doc/BRIEF.md
# SMBus Host Register Block

This block is the register front end of an SMBus host. Software programs a target address, a command code and outgoing data through an 8-bit register bus. It then writes the control register with the start bit set. The block checks the requested protocol and hands one abstract transaction request to a back-end bus engine. When the engine answers, the block captures any returned bytes. After a programmable settle time it posts a completion code in the status register. A 32-entry byte buffer holds block payloads. Software reaches the buffer through one auto-incrementing data port, and the engine reaches it through its own indexed port.

The sequencer has four states. SQ_IDLE waits for a start. SQ_ISSUE drives the request for exactly one cycle. SQ_WAIT waits for the engine's done pulse. SQ_SETTLE counts down the settle delay and then posts the pending status.

The transitions are as follows:
- SQ_IDLE goes to SQ_ISSUE on a start with a known protocol, and to SQ_SETTLE on a start with an unknown one.
- SQ_ISSUE goes to SQ_WAIT.
- SQ_WAIT goes to SQ_SETTLE on done.
- SQ_SETTLE goes to SQ_IDLE when the count reaches zero.
- SQ_ISSUE, SQ_WAIT and SQ_SETTLE all return to SQ_IDLE on a kill.

Top module: `smb_host_regs`

## Requirements
- R1: After reset every register reads 0x00, including the status register, the control register and the block data port.
- R2: The register offsets are: 0 status, 1 reserved, 2 control, 3 command code, 4 target address, 5 data 0, 6 data 1, 7 block data port. Offsets 3 to 6 read back the value last written. Offset 1 always reads 0x00. Control bit 6 (start) always reads 0. The other control bits read back as written.
- R3: Writing a 1 to status bit 1, 2, 3 or 4 clears that bit alone. Writing a 0 to a status bit leaves it unchanged.
- R4: A start is a control write with bit 6 set. A start in idle makes the status read 0x01 (busy) from the next cycle. For a known protocol, it also raises req_valid for exactly one cycle. The request carries these fields:
  - target address = address register bits 7:1;
  - read flag = address register bit 0;
  - protocol = control bits 4:2;
  - the command code;
  - data 0 and data 1.
- R5: The protocol codes are 0 quick, 1 byte, 2 byte with command, 3 word with command, and 5 block. Codes 4, 6 and 7 issue no request and complete with status 0x04.
- R6: A response with rsp_ack low completes with status 0x04 (device error) instead of 0x02 (done).
- R7: For an acknowledged read, data is captured as follows:
  - byte and byte-with-command load data 0;
  - word loads data 0 with the low byte and data 1 with the high byte;
  - block loads data 0 with the returned count.
  A write transaction changes neither data register.
- R8: The status stays 0x01 for exactly SETTLE_CYC cycles after the response is taken, then shows the pending code. For an unknown protocol, the count starts at the start write.
- R9: Each access to the block port uses the current buffer entry and then advances the index. The index wraps from 31 to 0. A read of the control register resets the index to 0. For a block write, the engine sees the buffer bytes at be_blk_idx. For a block read, the bytes the engine writes are later read at the block port.
- R10: A kill is a control write with bit 1 set. A kill while a transaction is outstanding (issuing, waiting or settling) sets the status to exactly 0x10 and drops any later response or pending update. A kill in idle leaves the status unchanged.
- R11: A start written while the status busy bit is set is ignored, and no second request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_rd | input | 1 | Read strobe (one access per cycle high) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| req_valid | output | 1 | One-cycle transaction request |
| req_taddr | output | 7 | 7-bit target address |
| req_read | output | 1 | 1 = read transaction |
| req_proto | output | 3 | Protocol code |
| req_cmd | output | 8 | Command code |
| req_wdata0 | output | 8 | Data 0 (low byte, or block count) |
| req_wdata1 | output | 8 | Data 1 (high byte) |
| rsp_done | input | 1 | One-cycle response pulse |
| rsp_ack | input | 1 | Target acknowledged |
| rsp_rdata0 | input | 8 | Returned low/only byte |
| rsp_rdata1 | input | 8 | Returned high byte |
| rsp_count | input | 8 | Returned block count |
| be_blk_idx | input | IW | Engine buffer index |
| be_blk_we | input | 1 | Engine buffer write enable |
| be_blk_wdata | input | 8 | Engine buffer write data |
| be_blk_rdata | output | 8 | Buffer byte at be_blk_idx |

## Verification
The bench runs the following transactions:
- a byte-with-command write;
- byte and word reads;
- a quick command;
- block writes and reads;
- a non-acknowledged target;
- two unknown protocol codes.

Reading both data registers after each one separates capture into the low byte from capture into the high byte, and separates capture from leaving the registers alone on writes. Counting busy samples after each response, and after an unknown code, separates an early or late status update from a correct one. Kills are tried during the wait phase, during settling and in idle. A second start during busy shows whether an extra request escapes. Filling the block buffer past its end shows whether the index wraps or spills.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ISSUE,
        SQ_WAIT,
        SQ_SETTLE
    } sq_state_e;

    localparam logic [2:0] PR_QUICK = 3'd0;
    localparam logic [2:0] PR_BYTE  = 3'd1;
    localparam logic [2:0] PR_BDATA = 3'd2;
    localparam logic [2:0] PR_WORD  = 3'd3;
    localparam logic [2:0] PR_BLOCK = 3'd5;

    localparam logic [7:0] ST_BUSY   = 8'h01;
    localparam logic [7:0] ST_DONE   = 8'h02;
    localparam logic [7:0] ST_DEVERR = 8'h04;
    localparam logic [7:0] ST_FAIL   = 8'h10;
    localparam logic [7:0] ST_W1C    = 8'h1E;

    localparam int OFF_STAT  = 0;
    localparam int OFF_CTL   = 2;
    localparam int OFF_CMD   = 3;
    localparam int OFF_SADDR = 4;
    localparam int OFF_D0    = 5;
    localparam int OFF_D1    = 6;
    localparam int OFF_BLK   = 7;

    localparam int CTL_START = 6;
    localparam int CTL_KILL  = 1;

    function automatic logic proto_known(input logic [2:0] p);
        return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
               (p == PR_WORD)  || (p == PR_BLOCK);
    endfunction

endpackage

// File: rtl/smb_blk_buf.sv
module smb_blk_buf #(
    parameter  int DEPTH = 32,
    localparam int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_rd,
    input  logic          host_wr,
    input  logic [7:0]    host_wdata,
    output logic [7:0]    host_rdata,
    input  logic          idx_clr,
    input  logic [IW-1:0] be_idx,
    input  logic          be_we,
    input  logic [7:0]    be_wdata,
    output logic [7:0]    be_rdata
);

    logic [7:0]    mem [DEPTH];
    logic [IW-1:0] idx_q;
    logic [IW-1:0] idx_nx;

    assign idx_nx     = (idx_q == IW'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
    assign host_rdata = mem[idx_q];
    assign be_rdata   = mem[be_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (idx_clr) begin
            idx_q <= '0;
        end else if (host_rd || host_wr) begin
            idx_q <= idx_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (be_we)   mem[be_idx] <= be_wdata;
            if (host_wr) mem[idx_q]  <= host_wdata;
        end
    end

    AST_IDX_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
        idx_clr |=> (idx_q == '0)); // R9

endmodule

// File: rtl/smb_seq.sv
module smb_seq
    import smb_host_pkg::*;
#(
    parameter int SETTLE_CYC = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_go,
    input  logic       kill_go,
    input  logic [2:0] proto,
    input  logic       w1c_go,
    input  logic [7:0] w1c_val,
    input  logic       rsp_done,
    input  logic       rsp_ack,
    output logic [7:0] stat,
    output logic       req_valid,
    output logic       accept,
    output logic       capture
);

    localparam int CW = $clog2(SETTLE_CYC + 1);

    sq_state_e     state_q, state_d;
    logic [7:0]    pend_q;
    logic [CW-1:0] cnt_q;

    assign req_valid = (state_q == SQ_ISSUE);
    assign accept    = (state_q == SQ_IDLE) && start_go;
    assign capture   = (state_q == SQ_WAIT) && rsp_done && rsp_ack && !kill_go;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (start_go) state_d = proto_known(proto) ? SQ_ISSUE : SQ_SETTLE;
            SQ_ISSUE:  state_d = kill_go ? SQ_IDLE : SQ_WAIT;
            SQ_WAIT:   if (kill_go) state_d = SQ_IDLE;
                       else if (rsp_done) state_d = SQ_SETTLE;
            SQ_SETTLE: if (kill_go || cnt_q == '0) state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat   <= '0;
            pend_q <= '0;
            cnt_q  <= '0;
        end else begin
            unique case (state_q)
                SQ_IDLE: begin
                    if (start_go) begin
                        stat <= ST_BUSY;
                        if (!proto_known(proto)) begin
                            pend_q <= ST_DEVERR;
                            cnt_q  <= CW'(SETTLE_CYC - 1);
                        end
                    end else if (w1c_go) begin
                        stat <= stat & ~(w1c_val & ST_W1C);
                    end
                end
                SQ_ISSUE: begin
                    if (kill_go) stat <= ST_FAIL;
                end
                SQ_WAIT: begin
                    if (kill_go) begin
                        stat <= ST_FAIL;
                    end else if (rsp_done) begin
                        pend_q <= rsp_ack ? ST_DONE : ST_DEVERR;
                        cnt_q  <= CW'(SETTLE_CYC - 1);
                    end
                end
                SQ_SETTLE: begin
                    if (kill_go)           stat  <= ST_FAIL;
                    else if (cnt_q == '0)  stat  <= pend_q;
                    else                   cnt_q <= cnt_q - 1'b1;
                end
            endcase
        end
    end

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R4
    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (stat == ST_BUSY)); // R4
    AST_BAD_PROTO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !proto_known(proto)) |=> !req_valid); // R5
    AST_SETTLE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SETTLE) |-> (cnt_q < CW'(SETTLE_CYC))); // R8
    AST_KILL_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != SQ_IDLE) && kill_go) |=> (stat == ST_FAIL)); // R10
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q != SQ_IDLE) && start_go) |=> !req_valid); // R11

endmodule

// File: rtl/smb_host_regs.sv
module smb_host_regs
    import smb_host_pkg::*;
#(
    parameter  int ADDR_W     = 4,
    parameter  int BLK_DEPTH  = 32,
    parameter  int SETTLE_CYC = 2000,
    localparam int IW         = $clog2(BLK_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              req_valid,
    output logic [6:0]        req_taddr,
    output logic              req_read,
    output logic [2:0]        req_proto,
    output logic [7:0]        req_cmd,
    output logic [7:0]        req_wdata0,
    output logic [7:0]        req_wdata1,
    input  logic              rsp_done,
    input  logic              rsp_ack,
    input  logic [7:0]        rsp_rdata0,
    input  logic [7:0]        rsp_rdata1,
    input  logic [7:0]        rsp_count,
    input  logic [IW-1:0]     be_blk_idx,
    input  logic              be_blk_we,
    input  logic [7:0]        be_blk_wdata,
    output logic [7:0]        be_blk_rdata
);

    logic sel_stat, sel_ctl, sel_cmd, sel_saddr, sel_d0, sel_d1, sel_blk;
    logic [7:0] ctl_q, cmd_q, saddr_q, d0_q, d1_q;
    logic [2:0] act_proto_q;
    logic       act_rd_q;
    logic [7:0] stat, blk_rdata;
    logic       start_go, kill_go, accept, capture;

    assign sel_stat  = (reg_addr == ADDR_W'(OFF_STAT));
    assign sel_ctl   = (reg_addr == ADDR_W'(OFF_CTL));
    assign sel_cmd   = (reg_addr == ADDR_W'(OFF_CMD));
    assign sel_saddr = (reg_addr == ADDR_W'(OFF_SADDR));
    assign sel_d0    = (reg_addr == ADDR_W'(OFF_D0));
    assign sel_d1    = (reg_addr == ADDR_W'(OFF_D1));
    assign sel_blk   = (reg_addr == ADDR_W'(OFF_BLK));

    assign start_go = reg_wr && sel_ctl && reg_wdata[CTL_START];
    assign kill_go  = reg_wr && sel_ctl && reg_wdata[CTL_KILL];

    smb_seq #(.SETTLE_CYC(SETTLE_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_go (start_go),
        .kill_go  (kill_go),
        .proto    (reg_wdata[4:2]),
        .w1c_go   (reg_wr && sel_stat),
        .w1c_val  (reg_wdata),
        .rsp_done (rsp_done),
        .rsp_ack  (rsp_ack),
        .stat     (stat),
        .req_valid(req_valid),
        .accept   (accept),
        .capture  (capture)
    );

    smb_blk_buf #(.DEPTH(BLK_DEPTH)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_rd   (reg_rd && sel_blk),
        .host_wr   (reg_wr && sel_blk),
        .host_wdata(reg_wdata),
        .host_rdata(blk_rdata),
        .idx_clr   (reg_rd && sel_ctl),
        .be_idx    (be_blk_idx),
        .be_we     (be_blk_we),
        .be_wdata  (be_blk_wdata),
        .be_rdata  (be_blk_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            cmd_q       <= '0;
            saddr_q     <= '0;
            d0_q        <= '0;
            d1_q        <= '0;
            act_proto_q <= '0;
            act_rd_q    <= 1'b0;
        end else begin
            if (reg_wr) begin
                if (sel_ctl)   ctl_q   <= reg_wdata & ~(8'h1 << CTL_START);
                if (sel_cmd)   cmd_q   <= reg_wdata;
                if (sel_saddr) saddr_q <= reg_wdata;
                if (sel_d0)    d0_q    <= reg_wdata;
                if (sel_d1)    d1_q    <= reg_wdata;
            end
            if (accept) begin
                act_proto_q <= reg_wdata[4:2];
                act_rd_q    <= saddr_q[0];
            end
            if (capture && act_rd_q) begin
                unique case (act_proto_q)
                    PR_BYTE, PR_BDATA: d0_q <= rsp_rdata0;
                    PR_WORD: begin
                        d0_q <= rsp_rdata0;
                        d1_q <= rsp_rdata1;
                    end
                    PR_BLOCK: d0_q <= rsp_count;
                    default: ;
                endcase
            end
        end
    end

    assign req_taddr  = saddr_q[7:1];
    assign req_read   = act_rd_q;
    assign req_proto  = act_proto_q;
    assign req_cmd    = cmd_q;
    assign req_wdata0 = d0_q;
    assign req_wdata1 = d1_q;

    always_comb begin
        reg_rdata = '0;
        if      (sel_stat)  reg_rdata = stat;
        else if (sel_ctl)   reg_rdata = ctl_q;
        else if (sel_cmd)   reg_rdata = cmd_q;
        else if (sel_saddr) reg_rdata = saddr_q;
        else if (sel_d0)    reg_rdata = d0_q;
        else if (sel_d1)    reg_rdata = d1_q;
        else if (sel_blk)   reg_rdata = blk_rdata;
    end

    AST_WRITE_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (capture && !act_rd_q && !reg_wr) |=> ($stable(d0_q) && $stable(d1_q))); // R7

endmodule

// File: tb/test_smb_host_regs.sv
`timescale 1ns/1ps
module test_smb_host_regs;

    localparam int SETTLE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       req_valid, req_read;
    logic [6:0] req_taddr;
    logic [2:0] req_proto;
    logic [7:0] req_cmd, req_wdata0, req_wdata1;
    logic       rsp_done = 1'b0, rsp_ack = 1'b0;
    logic [7:0] rsp_rdata0 = '0, rsp_rdata1 = '0, rsp_count = '0;
    logic [4:0] be_blk_idx = '0;
    logic       be_blk_we = 1'b0;
    logic [7:0] be_blk_wdata = '0, be_blk_rdata;

    always #2.5 clk = ~clk;

    smb_host_regs #(.ADDR_W(4), .BLK_DEPTH(32), .SETTLE_CYC(SETTLE)) i_smb_host_regs (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
        .req_taddr(req_taddr), .req_read(req_read), .req_proto(req_proto),
        .req_cmd(req_cmd), .req_wdata0(req_wdata0), .req_wdata1(req_wdata1),
        .rsp_done(rsp_done), .rsp_ack(rsp_ack), .rsp_rdata0(rsp_rdata0),
        .rsp_rdata1(rsp_rdata1), .rsp_count(rsp_count), .be_blk_idx(be_blk_idx),
        .be_blk_we(be_blk_we), .be_blk_wdata(be_blk_wdata), .be_blk_rdata(be_blk_rdata)
    );

    int n_cmp = 0, n_bad = 0;
    bit summary_done = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!summary_done) begin
            summary_done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        end
    endtask

    // scoreboard: driver pushes expected read values, monitor compares
    logic [7:0] sb_q[$];
    string      sb_tag[$];
    event       smp_ev;

    always @(smp_ev) begin
        logic [7:0] e;
        string t;
        e = sb_q.pop_front();
        t = sb_tag.pop_front();
        chk(reg_rdata == e, t, int'(reg_rdata), int'(e));
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        reg_addr = a; reg_rd = 1'b1;
        sb_q.push_back(e); sb_tag.push_back(t);
        #1 -> smp_ev;
        @(posedge clk); @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        reg_addr = 4'd0; reg_rd = 1'b1;
        #1;
        while (reg_rdata == 8'h01 && n < 1000) begin
            n++;
            @(negedge clk); #1;
        end
        reg_rd = 1'b0;
        @(negedge clk);
    endtask

    // back-end model
    int         req_cnt = 0, done_cnt = 0, m_delay = 3;
    logic [6:0] exp_taddr;
    logic       exp_read;
    logic [2:0] exp_proto;
    logic [7:0] exp_cmd, exp_d0;
    logic [7:0] exp_blk[32];

    initial begin
        forever begin
            @(negedge clk);
            if (req_valid) begin
                logic [6:0] ta; logic rf; logic [2:0] pr; logic [7:0] cm, w0;
                ta = req_taddr; rf = req_read; pr = req_proto; cm = req_cmd; w0 = req_wdata0;
                req_cnt++;
                chk(ta == exp_taddr, "R4 req target", int'(ta), int'(exp_taddr));
                chk(rf == exp_read,  "R4 req read flag", int'(rf), int'(exp_read));
                chk(pr == exp_proto, "R4 req protocol", int'(pr), int'(exp_proto));
                chk(cm == exp_cmd,   "R4 req command", int'(cm), int'(exp_cmd));
                chk(w0 == exp_d0,    "R4 req data0", int'(w0), int'(exp_d0));
                repeat (m_delay) @(negedge clk);
                if (pr == 3'd5 && rf) begin
                    for (int i = 0; i < 4; i++) begin
                        be_blk_we = 1'b1; be_blk_idx = 5'(i); be_blk_wdata = 8'(i * 3 + 1);
                        @(negedge clk);
                    end
                    be_blk_we = 1'b0;
                end
                if (pr == 3'd5 && !rf) begin
                    for (int i = 0; i < int'(w0); i++) begin
                        be_blk_idx = 5'(i);
                        #1 chk(be_blk_rdata == exp_blk[i], "R9 engine sees block byte",
                               int'(be_blk_rdata), int'(exp_blk[i]));
                        @(negedge clk);
                    end
                end
                rsp_ack    = (ta == 7'h50);
                rsp_rdata0 = cm ^ 8'h5A;
                rsp_rdata1 = cm + 8'd1;
                rsp_count  = 8'd4;
                rsp_done   = 1'b1;
                done_cnt++;
                @(negedge clk);
                rsp_done = 1'b0;
            end
        end
    end

    task automatic wait_done(input int old);
        do begin @(negedge clk); #1; end while (done_cnt == old);
        @(negedge clk);
    endtask

    task automatic set_exp(input logic [7:0] sa, input logic [2:0] p, input logic [7:0] c, input logic [7:0] d);
        exp_taddr = sa[7:1]; exp_read = sa[0]; exp_proto = p; exp_cmd = c; exp_d0 = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        summary();
        $finish;
    end

    initial begin
        int n, old, rc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        for (int a = 0; a < 8; a++) rd(4'(a), 8'h00, "R1 reset value");

        // R2 register map
        wr(4'd3, 8'h11); wr(4'd4, 8'hA0); wr(4'd5, 8'h33); wr(4'd6, 8'h44);
        wr(4'd1, 8'hFF);
        rd(4'd3, 8'h11, "R2 command"); rd(4'd4, 8'hA0, "R2 address");
        rd(4'd5, 8'h33, "R2 data0");   rd(4'd6, 8'h44, "R2 data1");
        rd(4'd1, 8'h00, "R2 reserved reads zero");

        // R4/R8 byte-with-command write
        set_exp(8'hA0, 3'd2, 8'h11, 8'h33);
        old = done_cnt;
        wr(4'd2, 8'h48);
        rd(4'd0, 8'h01, "R4 busy after start");
        rd(4'd2, 8'h08, "R2 start reads zero");
        wait_done(old);
        count_busy(n);
        chk(n == SETTLE, "R8 settle cycles", n, SETTLE);
        rd(4'd0, 8'h02, "R4 done status");
        rd(4'd5, 8'h33, "R7 write keeps data0");
        rd(4'd6, 8'h44, "R7 write keeps data1");
        wr(4'd0, 8'h04);
        rd(4'd0, 8'h02, "R3 clearing other bit leaves bit1");
        wr(4'd0, 8'h02);
        rd(4'd0, 8'h00, "R3 W1C bit1");

        // R7 word read
        wr(4'd4, 8'hA1); wr(4'd3, 8'h20);
        set_exp(8'hA1, 3'd3, 8'h20, 8'h33);
        old = done_cnt; wr(4'd2, 8'h4C); wait_done(old); count_busy(n);
        rd(4'd5, 8'h7A, "R7 word low byte");
        rd(4'd6, 8'h21, "R7 word high byte");
        rd(4'd0, 8'h02, "R7 word done");
        wr(4'd0, 8'h1E);

        // R7 byte read keeps data1
        wr(4'd3, 8'h30); wr(4'd6, 8'h99);
        set_exp(8'hA1, 3'd1, 8'h30, 8'h7A);
        old = done_cnt; wr(4'd2, 8'h44); wait_done(old); count_busy(n);
        rd(4'd5, 8'h6A, "R7 byte read data0");
        rd(4'd6, 8'h99, "R7 byte read keeps data1");
        wr(4'd0, 8'h02);

        // R5 quick
        wr(4'd4, 8'hA0);
        set_exp(8'hA0, 3'd0, 8'h30, 8'h6A);
        old = done_cnt; wr(4'd2, 8'h40); wait_done(old); count_busy(n);
        rd(4'd0, 8'h02, "R5 quick completes");
        wr(4'd0, 8'h02);

        // R6 no acknowledge
        wr(4'd4, 8'h40);
        set_exp(8'h40, 3'd2, 8'h30, 8'h6A);
        old = done_cnt; wr(4'd2, 8'h48); wait_done(old); count_busy(n);
        chk(n == SETTLE, "R8 settle after nack", n, SETTLE);
        rd(4'd0, 8'h04, "R6 device error");
        wr(4'd0, 8'h04);
        rd(4'd0, 8'h00, "R3 W1C bit2");

        // R5 unknown protocols 4 and 7
        rc = req_cnt;
        wr(4'd4, 8'hA0);
        wr(4'd2, 8'h50); count_busy(n);
        chk(n == SETTLE, "R8 settle for unknown code", n, SETTLE);
        rd(4'd0, 8'h04, "R5 code 4 device error");
        wr(4'd0, 8'h04);
        wr(4'd2, 8'h5C); count_busy(n);
        rd(4'd0, 8'h04, "R5 code 7 device error");
        wr(4'd0, 8'h04);
        chk(req_cnt == rc, "R5 no request for unknown code", req_cnt, rc);

        // R9 block write
        rd(4'd2, 8'h1C, "R2 control readback");
        for (int i = 0; i < 5; i++) begin
            exp_blk[i] = 8'(8'h10 + i);
            wr(4'd7, exp_blk[i]);
        end
        wr(4'd5, 8'd5); wr(4'd3, 8'h40);
        set_exp(8'hA0, 3'd5, 8'h40, 8'd5);
        old = done_cnt; wr(4'd2, 8'h54); wait_done(old); count_busy(n);
        rd(4'd0, 8'h02, "R9 block write done");
        rd(4'd5, 8'd5, "R7 block write keeps data0");
        wr(4'd0, 8'h02);

        // R7/R9 block read
        wr(4'd4, 8'hA1);
        set_exp(8'hA1, 3'd5, 8'h40, 8'd5);
        old = done_cnt; wr(4'd2, 8'h54); wait_done(old); count_busy(n);
        rd(4'd5, 8'd4, "R7 block count in data0");
        rd(4'd2, 8'h14, "R9 control read rewinds");
        for (int i = 0; i < 4; i++) rd(4'd7, 8'(i * 3 + 1), "R9 block read byte");
        wr(4'd0, 8'h02);

        // R9 wrap
        rd(4'd2, 8'h14, "R9 rewind before fill");
        for (int i = 0; i < 33; i++) wr(4'd7, 8'(i));
        rd(4'd2, 8'h14, "R9 rewind after fill");
        rd(4'd7, 8'd32, "R9 entry 0 after wrap");
        rd(4'd7, 8'd1, "R9 entry 1 after wrap");

        // R10 kill while waiting
        m_delay = 20;
        wr(4'd4, 8'hA0);
        set_exp(8'hA0, 3'd1, 8'h40, 8'd4);
        wr(4'd2, 8'h44);
        repeat (3) @(negedge clk);
        wr(4'd2, 8'h02);
        rd(4'd0, 8'h10, "R10 kill while waiting");
        repeat (40) @(negedge clk);
        rd(4'd0, 8'h10, "R10 late response dropped");
        wr(4'd0, 8'h10);
        rd(4'd0, 8'h00, "R3 W1C bit4");
        m_delay = 3;

        // R10 kill while settling
        wr(4'd2, 8'h50);
        @(negedge clk);
        wr(4'd2, 8'h02);
        repeat (SETTLE + 4) @(negedge clk);
        rd(4'd0, 8'h10, "R10 kill while settling");
        wr(4'd0, 8'h10);

        // R10 kill in idle
        wr(4'd2, 8'h02);
        rd(4'd0, 8'h00, "R10 kill in idle no effect");

        // R11 start while busy
        m_delay = 10;
        set_exp(8'hA0, 3'd2, 8'h40, 8'd4);
        rc = req_cnt; old = done_cnt;
        wr(4'd2, 8'h48);
        @(negedge clk);
        wr(4'd2, 8'h4C);
        wait_done(old); count_busy(n);
        chk(req_cnt == rc + 1, "R11 single request", req_cnt, rc + 1);
        rd(4'd0, 8'h02, "R11 first transaction completes");
        repeat (20) @(negedge clk);
        chk(req_cnt == rc + 1, "R11 no late request", req_cnt, rc + 1);

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule